// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked host and an untimed, single-bit-wide static RAM with a 20-bit address. The host presents one request at a time through a valid/ready handshake. Each request carries an address, a write flag and one bit of write data. The block turns each accepted request into the pin sequence the RAM expects. Read results come back as a one-cycle response pulse that carries the sampled bit.

The block measures every interval in whole clock periods. The integrator sets four parameters by rounding the RAM's nanosecond limits up to the clock period: access time, write pulse width, data setup and minimum cycle time. One netlist can therefore serve any speed grade.

Writes are strobed by write enable while chip enable stays low. The address and data change on the same edge that write enable falls, since the RAM needs no address setup before that edge. Write enable rises first, and chip enable follows one or more cycles later. Between requests, chip enable is high so the RAM rests in standby with its output floating.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, with no request, `ram_ce_n` and `ram_we_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle on, `ram_ce_n` is 0, `ram_addr` equals the accepted address and `req_ready` is 0.
- R3: For a write (`req_wr`=1), `ram_we_n` goes to 0 in the same cycle that `ram_ce_n` falls. It stays 0 for exactly WLOW = max(WP_CYC, DS_CYC) cycles, and `ram_din` holds the write bit throughout. `ram_we_n` is never 0 while `ram_ce_n` is 1.
- R4: For a read (`req_wr`=0), `ram_we_n` stays 1 for the whole access, and no response pulse follows a write.
- R5: For a read, `ram_dout` is sampled on the edge that comes ACCESS_CYC cycles after the address was driven. `rsp_valid` is then 1 for exactly one cycle, the (ACCESS_CYC+1)-th cycle after acceptance, with `rsp_rdata` set to that sample.
- R6: `ram_addr` does not change while `ram_ce_n` is 0.
- R7: `ram_ce_n` stays 0 for max(CYCLE_CYC, ACCESS_CYC) cycles on a read and for max(CYCLE_CYC, WLOW+1) cycles on a write. `req_ready` returns to 1 in the same cycle `ram_ce_n` rises. A request already waiting is accepted on the next edge, so only one standby cycle separates the two accesses.
- R8: While an access is in progress, `req_ready` is 0, and a held or changing request has no effect on `ram_addr` or on the access type.
- R9: A read returns the bit most recently written to that address, across the whole address range, and leaves other addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 1 | Write bit |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 1 | Read bit |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_din | output | 1 | RAM data input pin |
| ram_dout | input | 1 | RAM data output pin, may float |

## Verification
The checks assume that the host keeps its request fields steady only on the accepting edge, and may change them at any other time. They also assume that `ram_dout` is meaningful only during a read, after the access time has elapsed. The bench's RAM model returns the inverted bit until the programmed access time has passed since the last address change, so a capture made one cycle early is caught. It also floats its output whenever chip enable is high or write enable is low. Stimulus drives requests only when `req_ready` is 1, except in the held-request scenario. That scenario deliberately keeps `req_valid` high and scrambles the request fields while an access is in progress, to show they are ignored.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } asram_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CNT_W'(1);
    end else if (run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/asram_capture.sv
module asram_capture (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic pin,
  output logic valid,
  output logic data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= 1'b0;
    end else begin
      valid <= sample;
      if (sample) data <= pin;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R5

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned ACCESS_CYC = 4,
  parameter int unsigned WLOW       = 3,
  parameter int unsigned RD_LEN     = 4,
  parameter int unsigned WR_LEN     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic              start,
  output logic              busy,
  output logic              sample,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_din
);

  localparam logic [CNT_W-1:0] WLOW_C = CNT_W'(WLOW);
  localparam logic [CNT_W-1:0] ACC_C  = CNT_W'(ACCESS_CYC);
  localparam logic [CNT_W-1:0] RDL_C  = CNT_W'(RD_LEN);
  localparam logic [CNT_W-1:0] WRL_C  = CNT_W'(WR_LEN);

  asram_state_e state;
  logic         is_wr;
  logic         last;

  assign busy   = (state == ST_BUSY);
  assign start  = (state == ST_IDLE) && req_valid && req_ready;
  assign last   = busy && (cnt == (is_wr ? WRL_C : RDL_C));
  assign sample = busy && !is_wr && (cnt == ACC_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      is_wr     <= 1'b0;
      req_ready <= 1'b1;
      ram_addr  <= '0;
      ram_ce_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      ram_din   <= 1'b0;
    end else begin
      if (start) begin
        state     <= ST_BUSY;
        is_wr     <= req_wr;
        req_ready <= 1'b0;
        ram_addr  <= req_addr;
        ram_din   <= req_wdata;
        ram_ce_n  <= 1'b0;
        ram_we_n  <= !req_wr;
      end else if (busy) begin
        if (is_wr && (cnt == WLOW_C)) ram_we_n <= 1'b1;
        if (last) begin
          state     <= ST_IDLE;
          req_ready <= 1'b1;
          ram_ce_n  <= 1'b1;
          ram_we_n  <= 1'b1;
        end
      end
    end
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_ce_n); // R3
  AST_DIN_HELD: assert property (@(posedge clk) disable iff (rst)
    (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_din)); // R3
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_wr) |-> ram_we_n); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr)); // R6
  AST_READY_ON_END: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_ce_n) |-> req_ready); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !ram_ce_n |-> !req_ready); // R8

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned ACCESS_CYC = 4,
  parameter int unsigned WP_CYC     = 3,
  parameter int unsigned DS_CYC     = 2,
  parameter int unsigned CYCLE_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_din,
  input  logic              ram_dout
);

  localparam int unsigned WLOW    = umax(WP_CYC, DS_CYC);
  localparam int unsigned RD_LEN  = umax(CYCLE_CYC, ACCESS_CYC);
  localparam int unsigned WR_LEN  = umax(CYCLE_CYC, WLOW + 1);
  localparam int unsigned MAX_LEN = umax(RD_LEN, WR_LEN);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic             start;
  logic             busy;
  logic             sample;

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .run   (busy),
    .cnt   (cnt)
  );

  asram_seq #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .ACCESS_CYC (ACCESS_CYC),
    .WLOW       (WLOW),
    .RD_LEN     (RD_LEN),
    .WR_LEN     (WR_LEN)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cnt       (cnt),
    .start     (start),
    .busy      (busy),
    .sample    (sample),
    .ram_addr  (ram_addr),
    .ram_ce_n  (ram_ce_n),
    .ram_we_n  (ram_we_n),
    .ram_din   (ram_din)
  );

  asram_capture u_cap (
    .clk    (clk),
    .rst    (rst),
    .sample (sample),
    .pin    (ram_dout),
    .valid  (rsp_valid),
    .data   (rsp_rdata)
  );

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  localparam int AW      = 20;
  localparam int ACC     = 4;
  localparam int WP      = 3;
  localparam int DS      = 2;
  localparam int CYC     = 4;
  localparam int WLOW_E  = (WP > DS) ? WP : DS;
  localparam int RDLEN_E = (CYC > ACC) ? CYC : ACC;
  localparam int WRLEN_E = (CYC > WLOW_E + 1) ? CYC : WLOW_E + 1;
  localparam real ACC_NS = 15.0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_wdata = 1'b0;
  logic          rsp_valid;
  logic          rsp_rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_ce_n;
  logic          ram_we_n;
  logic          ram_din;
  logic          ram_dout;

  int n_chk  = 0;
  int n_fail = 0;

  asram_ctrl #(.ADDR_W(AW), .ACCESS_CYC(ACC), .WP_CYC(WP), .DS_CYC(DS), .CYCLE_CYC(CYC)) u_asram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_din(ram_din),
    .ram_dout(ram_dout)
  );

  always #2 clk = ~clk;

  // RAM model: store on write enable rising, slow output until access time passes
  bit  mem [int unsigned];
  real t_addr = 0.0;

  always @(ram_addr) t_addr = $realtime;

  always @(posedge ram_we_n) begin
    if (!ram_ce_n) mem[int'(ram_addr)] = ram_din;
  end

  initial begin
    #0.5;
    forever begin
      bit v;
      v = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 1'b0;
      if (ram_ce_n || !ram_we_n) ram_dout = 1'bz;
      else if (($realtime - t_addr) >= ACC_NS) ram_dout = v;
      else ram_dout = ~v;
      #0.5;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One access; samples at falling edges. Sample 1 is the cycle after acceptance.
  task automatic run(input bit wr, input logic [AW-1:0] a, input bit d, input bit hold,
                     output bit rd, output int ce_lo, output int we_lo, output int rsp_at,
                     output int rsp_cnt);
    bit stab_ok = 1'b1;
    bit din_ok  = 1'b1;
    bit busy_ok = 1'b1;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    else begin req_addr = ~a; req_wr = !wr; req_wdata = !d; end
    ce_lo = 0; we_lo = 0; rsp_at = 0; rsp_cnt = 0; rd = 1'b0;
    for (int s = 1; s <= 40; s++) begin
      if (!ram_ce_n) begin
        ce_lo++;
        if (ram_addr != a) stab_ok = 1'b0;
        if (req_ready) busy_ok = 1'b0;
      end
      if (!ram_we_n) begin
        we_lo++;
        if (ram_din != d) din_ok = 1'b0;
      end
      if (rsp_valid) begin rsp_at = s; rsp_cnt++; rd = rsp_rdata; end
      if (ram_ce_n) break;
      @(negedge clk);
    end
    if (hold) req_valid = 1'b0;
    chk(stab_ok, "R6 address held while enabled", int'(stab_ok), 1);
    chk(busy_ok, "R8 ready low during access", int'(busy_ok), 1);
    if (wr) chk(din_ok, "R3 write bit held while strobed", int'(din_ok), 1);
    chk(req_ready, "R7 ready back when enable rises", int'(req_ready), 1);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input bit d);
    bit rd; int ce_lo, we_lo, rsp_at, rsp_cnt;
    run(1'b1, a, d, 1'b0, rd, ce_lo, we_lo, rsp_at, rsp_cnt);
    chk(we_lo == WLOW_E, "R3 write strobe length", we_lo, WLOW_E);
    chk(ce_lo == WRLEN_E, "R7 write access length", ce_lo, WRLEN_E);
    chk(rsp_cnt == 0, "R4 no response after write", rsp_cnt, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit exp, input string tag);
    bit rd; int ce_lo, we_lo, rsp_at, rsp_cnt;
    run(1'b0, a, 1'b0, 1'b0, rd, ce_lo, we_lo, rsp_at, rsp_cnt);
    chk(we_lo == 0, "R4 read keeps strobe high", we_lo, 0);
    chk(ce_lo == RDLEN_E, "R7 read access length", ce_lo, RDLEN_E);
    chk(rsp_at == ACC + 1 && rsp_cnt == 1, "R5 response timing", rsp_at, ACC + 1);
    chk(rd == exp, tag, int'(rd), int'(exp));
  endtask

  task automatic t_reset;
    chk(ram_ce_n && ram_we_n && req_ready && !rsp_valid, "R1 state in reset",
        {ram_ce_n, ram_we_n, req_ready, rsp_valid}, 4'b1110);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_we_n && req_ready && !rsp_valid, "R1 idle after reset",
        {ram_ce_n, ram_we_n, req_ready, rsp_valid}, 4'b1110);
  endtask

  task automatic t_accept;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = 20'h3C0F1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ram_ce_n && ram_addr == 20'h3C0F1 && !req_ready, "R2 accept drives pins",
        int'(ram_addr), 20'h3C0F1);
    repeat (RDLEN_E + 1) @(negedge clk);
  endtask

  task automatic t_write_read;
    do_write(20'h00000, 1'b1);
    do_write(20'hFFFFF, 1'b1);
    do_write(20'h5A5A5, 1'b0);
    do_write(20'h5A5A4, 1'b1);
    do_read(20'h00000, 1'b1, "R9 read back low end");
    do_read(20'hFFFFF, 1'b1, "R9 read back high end");
    do_read(20'h5A5A5, 1'b0, "R9 neighbour left intact");
    do_read(20'h5A5A4, 1'b1, "R9 read back pattern");
    do_read(20'h12345, 1'b0, "R5 never-written location");
  endtask

  task automatic t_overwrite;
    do_write(20'h0BEEF, 1'b1);
    do_write(20'h0BEEF, 1'b0);
    do_read(20'h0BEEF, 1'b0, "R9 latest write wins");
  endtask

  task automatic t_held_request;
    bit rd; int ce_lo, we_lo, rsp_at, rsp_cnt;
    run(1'b0, 20'hFFFFF, 1'b0, 1'b1, rd, ce_lo, we_lo, rsp_at, rsp_cnt);
    chk(we_lo == 0, "R8 held request did not turn read into write", we_lo, 0);
    chk(rd == 1'b1, "R8 held request read data", int'(rd), 1);
    @(negedge clk);
    chk(ram_ce_n && req_ready, "R8 no extra access from held request", int'(ram_ce_n), 1);
  endtask

  task automatic t_back_to_back;
    bit rd; int ce_lo, we_lo, rsp_at, rsp_cnt;
    run(1'b1, 20'h00777, 1'b1, 1'b0, rd, ce_lo, we_lo, rsp_at, rsp_cnt);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = 20'h00777;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ram_ce_n, "R7 one standby cycle between accesses", int'(ram_ce_n), 0);
    repeat (ACC) @(negedge clk);
    chk(rsp_valid && rsp_rdata, "R5 back-to-back read data", int'(rsp_rdata), 1);
    repeat (RDLEN_E) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_accept();
    t_write_read();
    t_overwrite();
    t_held_request();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule